// File: doc/BRIEF.md
# 32-to-1 Word Serializer with Word-Clock Generator

This block turns a stream of 32-bit parallel words into one serial bit stream at the fast bit-clock rate. A free-running divide-by-32 counter in the bit-clock domain produces a word-rate clock. That clock is sent to the upstream logic, which launches each new word from it. The same clock comes back on a separate input and captures the parallel word into an input register. Because the returned clock reaches the input register with the same delay as the data, the upstream launch and the local capture stay aligned.

Once per word period, at a fixed counter phase well after the capture edge, the captured word is copied into a shift register in the bit-clock domain. The shift register then moves one place per bit cycle, least significant bit first. A final flop on the bit clock drives the serial output. A synchronous reset clears the counter, the shift register and the serial flop. After reset the first word comes out after a fixed, known latency.

Top module: `word_serializer`

## Requirements
- R1: `wclk_out` is low while `rst` is high. After reset is released, count rising `clk_bit` edges as n = 1, 2, and so on. `wclk_out` is high after edge n exactly when (n mod 32) is 16 or more, which gives a period of 32 bit cycles and a 50% duty cycle.
- R2: `par_in` is sampled only on the rising edge of `wclk_in`. Changes to `par_in` at any other time have no effect on the serial output.
- R3: Number the words captured after reset w = 0, 1, and so on. Word w is captured at the `wclk_in` rise that follows edge 16+32w. It is reloaded into the shift register exactly once, at edge 25+32w, which is counter phase 24. Bit b of that word is on `ser_out` after edge 26+32w+b.
- R4: Bits leave in index order. Bit 0 is sent first and bit 31 last.
- R5: Consecutive words follow one another with no gap. Bit 0 of word w+1 comes on the bit cycle right after bit 31 of word w.
- R6: While `rst` is high at a rising `clk_bit` edge, the divider, the shift register and `ser_out` are cleared. After release, `ser_out` stays 0 until the first captured word appears, at edge 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | 32 | Parallel word from the upstream device |
| wclk_in | input | 1 | Returned word clock; its rising edge captures `par_in` |
| wclk_out | output | 1 | Word-rate clock, `clk_bit` divided by 32 |
| ser_out | output | 1 | Registered serial data, bit 0 of each word first |

## Verification
The bench aims at single-bit and all-ones or all-zeros words at both ends of the word. A reversed shift direction would send 0x80000000 out as 0x00000001, and a one-cycle slip in the reload phase would shift every bit by one cycle and break the latency check. It overwrites `par_in` with the complement of the word after each capture edge. A design that sampled on the bit clock, or on a level of the word clock, would then send the wrong word. A reset in the middle of a word checks that the serial flop drops at once and that the next stream restarts at the latency given in R3, with no leftover bits from the old shift register.

// File: rtl/ws_pkg.sv
package ws_pkg;
    // Default geometry of the serializer
    localparam int unsigned DEF_WORD_W     = 32;
    // Counter phase at which the captured word is moved into the shifter
    localparam int unsigned DEF_LOAD_PHASE = 24;
endpackage

// File: rtl/ws_timing_gen.sv
module ws_timing_gen #(
    parameter int unsigned WORD_W     = ws_pkg::DEF_WORD_W,
    parameter int unsigned LOAD_PHASE = ws_pkg::DEF_LOAD_PHASE
) (
    input  logic clk_bit,
    input  logic rst,
    output logic wclk_o,
    output logic load_o
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam int unsigned HALF  = WORD_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wclk;
        logic             load;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.wclk = (st_d.cnt >= CNT_W'(HALF));
        st_d.load = (st_d.cnt == CNT_W'(LOAD_PHASE));
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_bit) begin
        st_q <= st_d;
    end

    assign wclk_o = st_q.wclk;
    assign load_o = st_q.load;

    AST_WCLK_RISE_PHASE: assert property (@(posedge clk_bit) disable iff (rst)
        $rose(st_q.wclk) |-> $past(st_q.cnt) == CNT_W'(HALF - 1)); // R1

    AST_DIV_RESET: assert property (@(posedge clk_bit)
        rst |=> (st_q.cnt == '0) && !st_q.wclk && !st_q.load); // R6
endmodule

// File: rtl/ws_capture_reg.sv
module ws_capture_reg #(
    parameter int unsigned WORD_W = ws_pkg::DEF_WORD_W
) (
    input  logic              wclk_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] cap_d, cap_q;

    always_comb begin
        cap_d = data_i;
    end

    always_ff @(posedge wclk_i) begin
        cap_q <= cap_d;
    end

    assign word_o = cap_q;
endmodule

// File: rtl/ws_shift_out.sv
module ws_shift_out #(
    parameter int unsigned WORD_W = ws_pkg::DEF_WORD_W
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              ser;
    } so_state_t;

    so_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ser = st_q.sh[0];
        if (load_i) begin
            st_d.sh = word_i;
        end else begin
            st_d.sh = {1'b0, st_q.sh[WORD_W-1:1]};
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_bit) begin
        st_q <= st_d;
    end

    assign ser_o = st_q.ser;

    AST_FIRST_BIT_OUT: assert property (@(posedge clk_bit) disable iff (rst)
        $past(load_i) |=> ser_o == $past(word_i[0], 2)); // R4

    AST_SHIFT_RESET: assert property (@(posedge clk_bit)
        rst |=> (st_q.sh == '0) && !ser_o); // R6
endmodule

// File: rtl/word_serializer.sv
module word_serializer #(
    parameter int unsigned WORD_W     = ws_pkg::DEF_WORD_W,
    parameter int unsigned LOAD_PHASE = ws_pkg::DEF_LOAD_PHASE
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic [WORD_W-1:0] par_in,
    input  logic              wclk_in,
    output logic              wclk_out,
    output logic              ser_out
);
    localparam int unsigned CNT_W = $clog2(WORD_W);

    logic              load;
    logic [WORD_W-1:0] cap_word;

    ws_timing_gen #(.WORD_W(WORD_W), .LOAD_PHASE(LOAD_PHASE)) i_timing (
        .clk_bit (clk_bit),
        .rst     (rst),
        .wclk_o  (wclk_out),
        .load_o  (load)
    );

    ws_capture_reg #(.WORD_W(WORD_W)) i_capture (
        .wclk_i (wclk_in),
        .data_i (par_in),
        .word_o (cap_word)
    );

    ws_shift_out #(.WORD_W(WORD_W)) i_shift (
        .clk_bit (clk_bit),
        .rst     (rst),
        .load_i  (load),
        .word_i  (cap_word),
        .ser_o   (ser_out)
    );

    // Spacing monitor for reload pulses
    logic [CNT_W:0] gap_d, gap_q;
    logic           seen_d, seen_q;

    always_comb begin
        gap_d  = gap_q + 1'b1;
        seen_d = seen_q;
        if (load) begin
            gap_d  = '0;
            seen_d = 1'b1;
        end
        if (rst) begin
            gap_d  = '0;
            seen_d = 1'b0;
        end
    end

    always_ff @(posedge clk_bit) begin
        gap_q  <= gap_d;
        seen_q <= seen_d;
    end

    AST_LOAD_PERIOD: assert property (@(posedge clk_bit) disable iff (rst)
        (load && seen_q) |-> gap_q == (CNT_W+1)'(WORD_W - 1)); // R3

    AST_LOAD_AFTER_CAPTURE: assert property (@(posedge clk_bit) disable iff (rst)
        load |-> wclk_out); // R3
endmodule

// File: tb/test_word_serializer.sv
module test_word_serializer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] par_in = '0;
    logic        wclk_out;
    logic        wclk_ret;
    logic        ser_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    // Return path of the word clock through the upstream device
    assign #1 wclk_ret = wclk_out;

    word_serializer i_word_serializer (
        .clk_bit  (clk),
        .rst      (rst),
        .par_in   (par_in),
        .wclk_in  (wclk_ret),
        .wclk_out (wclk_out),
        .ser_out  (ser_out)
    );

    function automatic logic [31:0] wordf(input int w);
        case (w)
            0:       return 32'h0000_0001;
            1:       return 32'h8000_0000;
            2:       return 32'hFFFF_FFFF;
            3:       return 32'h0000_0000;
            4:       return 32'hA5C3_0F96;
            default: return (32'(w) * 32'h9E37_79B9) ^ (32'(w) << 11) ^ 32'h1357_9BDF;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic hold_reset(input int k);
        rst = 1'b1;
        repeat (k) begin
            @(posedge clk);
            @(negedge clk);
            chk("R6 ser_out in reset", ser_out, 1'b0);
            chk("R1/R6 wclk_out in reset", wclk_out, 1'b0);
        end
    endtask

    // Reference: edges numbered from reset release, latency per R3
    task automatic run_words(input int base, input int nwords);
        int n = 0;
        par_in = wordf(base);
        rst    = 1'b0;
        while (n < 26 + 32 * nwords) begin
            logic exp_bit;
            string tag;
            @(posedge clk);
            n++;
            @(negedge clk);
            chk("R1 wclk_out phase", wclk_out, (n % 32) >= 16);
            if (n < 26) begin
                exp_bit = 1'b0;
                tag = "R6 idle after reset";
            end else begin
                logic [31:0] wv;
                int b;
                wv = wordf(base + (n - 26) / 32);
                b  = (n - 26) % 32;
                exp_bit = wv[b];
                if (b == 0 && n >= 58) tag = "R5 back-to-back word";
                else if (b == 0)       tag = "R3 first-bit latency";
                else                   tag = "R4/R2 bit order and capture";
            end
            chk(tag, ser_out, exp_bit);
            if (n % 32 == 0)  par_in = wordf(base + n / 32);
            if (n % 32 == 20) par_in = ~wordf(base + n / 32); // R2 off-edge change
        end
    endtask

    initial begin
        hold_reset(4);
        run_words(0, 9);
        hold_reset(3);
        run_words(100, 6);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule